// File: doc/BRIEF.md
# Parallel FPGA Configuration Sequencer

This block is a hardware master that loads a configuration bitstream into a target FPGA through the target's byte-wide slave parallel configuration port. It takes bytes from an upstream valid/ready stream and a total byte count. It then runs the whole configuration handshake. First it pulses the program pin and waits for INIT to drop and rise again. Next it selects the port and waits for the target to settle. It clocks the bytes in one by one and ends with a check of DONE and INIT.

While the load runs, the block watches INIT for a mid-load fault. It stops early when DONE rises, and after each strobe it can wait for BUSY to fall. Each phase has its own timeout. Any failure sends the sequencer to an abort state, which reports a code and the number of bytes clocked so far. A start pulse is honoured only from idle, success or abort. All status pins pass through a two-flop synchroniser. Every delay and timeout is a parameter counted in system clock cycles.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset the program, chip-select, write and configuration-clock pins sit high (inactive), and busy_o, ok_o, err_o and s_ready_o are low.
- R2: On start the program pin is driven low for at least PROG_CYC cycles and stays low until INIT is seen low. Chip-select never goes low while the program pin is low.
- R3: If INIT is not seen low within INIT_TO_CYC cycles of the end of the minimum pulse, the block aborts with err_code_o = 1 and err_offset_o = 0.
- R4: If INIT is not seen high within INIT_TO_CYC cycles of the program pin release, the block aborts with err_code_o = 2.
- R5: Chip-select and write go low together, and they stay low for at least SETTLE_CYC cycles before the first configuration-clock fall.
- R6: Each accepted byte is placed on cfg_data_o and followed by one configuration-clock low/high pulse, with the data stable at the rising edge. The target receives the bytes in stream order, and exactly total_bytes_i of them arrive when nothing else intervenes.
- R7: INIT seen low during the data phase aborts the load with err_code_o = 3. err_offset_o then holds the number of bytes clocked, and no further byte is clocked.
- R8: DONE seen high before the last byte ends the data phase. No further byte is clocked, and the load finishes with ok_o.
- R9: With the BUSY check on, the block waits for BUSY low after each strobe. If BUSY stays high for BUSY_TO_CYC cycles, the block aborts with err_code_o = 5 and err_offset_o equal to the bytes clocked.
- R10: After the data phase, chip-select and write are released. DONE and INIT both high give ok_o. Otherwise the block aborts after DONE_TO_CYC cycles with err_code_o = 4 and err_offset_o equal to the bytes clocked; this also covers a zero-byte load.
- R11: busy_o is high from the start pulse until success or abort. A start pulse that arrives while busy_o is high has no effect on the running load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| total_bytes_i | input | CNT_W | Number of bytes to load, latched on start |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| cfg_prog_n_o | output | 1 | Program pin, active low |
| cfg_cs_n_o | output | 1 | Chip-select pin, active low |
| cfg_wr_n_o | output | 1 | Write pin, active low |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 8 | Configuration data bus |
| cfg_init_n_i | input | 1 | INIT status from target, low = reset or fault |
| cfg_done_i | input | 1 | DONE status from target |
| cfg_busy_i | input | 1 | BUSY status from target |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence succeeded |
| err_o | output | 1 | Last sequence aborted |
| err_code_o | output | 3 | Abort reason (1..5) |
| err_offset_o | output | CNT_W | Bytes clocked when the abort happened |

## Verification
The bench drives a behavioural model of the target, and the stream applies random valid gaps to random byte payloads. Several clean loads of random length confirm byte order, count, pulse width and settle time. Other runs make the target withhold the INIT fall or the INIT rise, raise INIT low at a chosen byte, raise DONE early, hold BUSY high or never raise DONE. Each of these has only one correct error code and offset, so together they separate the abort paths and show which byte the block stops at. A single-byte load and a zero-byte load cover the ends of the count range. A start pulse sent in the middle of a load tests that the running sequence ignores it.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_INIT_LO,
    ST_INIT_HI,
    ST_SETTLE,
    ST_FETCH,
    ST_STROBE,
    ST_GAP,
    ST_FINAL,
    ST_OK,
    ST_ABORT
  } cfg_state_e;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_INIT_LO   = 3'd1;
  localparam logic [2:0] ERR_INIT_HI   = 3'd2;
  localparam logic [2:0] ERR_LOAD_INIT = 3'd3;
  localparam logic [2:0] ERR_DONE_TO   = 3'd4;
  localparam logic [2:0] ERR_BUSY_TO   = 3'd5;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
  parameter int unsigned W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfgld_bytecnt.sv
module cfgld_bytecnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TMR_W       = 27,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PROG_CYC    = 64,
  parameter int unsigned INIT_TO_CYC = 100_000_000,
  parameter int unsigned SETTLE_CYC  = 2_000_000,
  parameter int unsigned BUSY_TO_CYC = 1_000_000,
  parameter int unsigned DONE_TO_CYC = 40_000_000,
  parameter bit          CHECK_BUSY  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_bytes_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             cfg_prog_n_o,
  output logic             cfg_cs_n_o,
  output logic             cfg_wr_n_o,
  output logic             cfg_cclk_o,
  output logic [7:0]       cfg_data_o,
  input  logic             cfg_init_n_i,
  input  logic             cfg_done_i,
  input  logic             cfg_busy_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic [CNT_W-1:0] err_offset_o
);
  // Gap after each strobe long enough for a status change caused by that
  // strobe to cross the synchroniser before the next byte is considered.
  localparam int unsigned HOLD_CYC = SYNC_STAGES + 2;
  localparam int unsigned HOLD_W   = $clog2(HOLD_CYC + 1);

  localparam logic [TMR_W-1:0] T_PROG   = TMR_W'(PROG_CYC);
  localparam logic [TMR_W-1:0] T_INIT   = TMR_W'(INIT_TO_CYC);
  localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0] T_BUSY   = TMR_W'(BUSY_TO_CYC);
  localparam logic [TMR_W-1:0] T_DONE   = TMR_W'(DONE_TO_CYC);
  localparam logic [HOLD_W-1:0] T_HOLD  = HOLD_W'(HOLD_CYC);

  // ---------------- status synchronisers ----------------
  logic [2:0] stat_s;
  logic       init_s, done_s, busy_s, busy_clear;

  cfgld_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cfg_busy_i, cfg_done_i, cfg_init_n_i}),
    .q_o (stat_s)
  );

  assign init_s = stat_s[0];
  assign done_s = stat_s[1];
  assign busy_s = stat_s[2];

  if (CHECK_BUSY) begin : g_busy_on
    assign busy_clear = !busy_s;
  end else begin : g_busy_off
    assign busy_clear = 1'b1;
  end

  // ---------------- state and helpers ----------------
  cfg_state_e state_q, state_d;

  logic             tmr_ld, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             hold_ld, hold_zero;
  logic             cnt_clr, cnt_inc, cnt_hit;
  logic [CNT_W-1:0] cnt, total_q;
  logic             take;
  logic [2:0]       code_d;

  cfgld_timer #(.W(TMR_W)) u_phase_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cfgld_timer #(.W(HOLD_W)) u_hold_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (hold_ld),
    .val_i  (T_HOLD),
    .zero_o (hold_zero)
  );

  cfgld_bytecnt #(.W(CNT_W)) u_bytes (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (total_q),
    .cnt_o   (cnt),
    .hit_o   (cnt_hit)
  );

  assign s_ready_o = (state_q == ST_FETCH) && !cnt_hit && !done_s && init_s;
  assign cnt_inc   = (state_q == ST_STROBE);

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = T_PROG;
    hold_ld = 1'b0;
    cnt_clr = 1'b0;
    take    = 1'b0;
    code_d  = ERR_NONE;

    unique case (state_q)
      ST_IDLE, ST_OK, ST_ABORT: begin
        if (start_i) begin
          state_d = ST_PULSE;
          tmr_ld  = 1'b1;
          tmr_val = T_PROG;
          cnt_clr = 1'b1;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          state_d = ST_INIT_LO;
          tmr_ld  = 1'b1;
          tmr_val = T_INIT;
        end
      end
      ST_INIT_LO: begin
        if (!init_s) begin
          state_d = ST_INIT_HI;
          tmr_ld  = 1'b1;
          tmr_val = T_INIT;
        end else if (tmr_zero) begin
          state_d = ST_ABORT;
          code_d  = ERR_INIT_LO;
        end
      end
      ST_INIT_HI: begin
        if (init_s) begin
          state_d = ST_SETTLE;
          tmr_ld  = 1'b1;
          tmr_val = T_SETTLE;
        end else if (tmr_zero) begin
          state_d = ST_ABORT;
          code_d  = ERR_INIT_HI;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (cnt_hit || done_s) begin
          state_d = ST_FINAL;
          tmr_ld  = 1'b1;
          tmr_val = T_DONE;
        end else if (!init_s) begin
          state_d = ST_ABORT;
          code_d  = ERR_LOAD_INIT;
        end else if (s_valid_i) begin
          state_d = ST_STROBE;
          take    = 1'b1;
        end
      end
      ST_STROBE: begin
        state_d = ST_GAP;
        hold_ld = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = T_BUSY;
      end
      ST_GAP: begin
        if (!init_s) begin
          state_d = ST_ABORT;
          code_d  = ERR_LOAD_INIT;
        end else if (hold_zero && busy_clear) begin
          state_d = ST_FETCH;
        end else if (hold_zero && tmr_zero) begin
          state_d = ST_ABORT;
          code_d  = ERR_BUSY_TO;
        end
      end
      ST_FINAL: begin
        if (done_s && init_s) begin
          state_d = ST_OK;
        end else if (tmr_zero) begin
          state_d = ST_ABORT;
          code_d  = ERR_DONE_TO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- registered state and pins ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      total_q      <= '0;
      cfg_prog_n_o <= 1'b1;
      cfg_cs_n_o   <= 1'b1;
      cfg_wr_n_o   <= 1'b1;
      cfg_cclk_o   <= 1'b1;
      cfg_data_o   <= '0;
      busy_o       <= 1'b0;
      ok_o         <= 1'b0;
      err_o        <= 1'b0;
      err_code_o   <= ERR_NONE;
      err_offset_o <= '0;
    end else begin
      state_q      <= state_d;
      cfg_prog_n_o <= !(state_d == ST_PULSE || state_d == ST_INIT_LO);
      cfg_cs_n_o   <= !(state_d inside {ST_SETTLE, ST_FETCH, ST_STROBE, ST_GAP});
      cfg_wr_n_o   <= !(state_d inside {ST_SETTLE, ST_FETCH, ST_STROBE, ST_GAP});
      cfg_cclk_o   <= (state_d != ST_STROBE);
      busy_o       <= !(state_d inside {ST_IDLE, ST_OK, ST_ABORT});
      ok_o         <= (state_d == ST_OK);
      err_o        <= (state_d == ST_ABORT);
      if (take) cfg_data_o <= s_data_i;
      if (cnt_clr) begin
        total_q      <= total_bytes_i;
        err_code_o   <= ERR_NONE;
        err_offset_o <= '0;
      end
      if (state_d == ST_ABORT && state_q != ST_ABORT) begin
        err_code_o   <= code_d;
        err_offset_o <= cnt;
      end
    end
  end
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       prog_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic       cclk,
  input logic [7:0] data,
  input logic       s_valid,
  input logic       s_ready,
  input logic       busy,
  input logic       ok,
  input logic       err,
  input logic [2:0] code
);
  // R1: the cycle after reset all pins are idle and no status is raised
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (prog_n && cs_n && wr_n && cclk && !busy && !ok && !err));

  // R2: port is never selected while the program pin is held
  assert_no_select_in_prog_R2: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> prog_n);

  // R6: configuration clock falls only while selected for writing
  assert_strobe_selected_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cclk) |-> (!cs_n && !wr_n));

  // R6: data does not move across the rising clock edge
  assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk) |-> $stable(data));

  // R10: success is only reported with the port released
  assert_release_on_ok_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ok) |-> (cs_n && wr_n && prog_n));

  // R3: an abort always carries a nonzero reason
  assert_abort_code_R3: assert property (@(posedge clk) disable iff (rst)
    err |-> (code != 3'd0));

  // R11: stream bytes are only taken while a sequence runs
  assert_take_in_seq_R11: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |-> busy);
endmodule

bind fpga_cfg_loader cfgld_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .prog_n  (cfg_prog_n_o),
  .cs_n    (cfg_cs_n_o),
  .wr_n    (cfg_wr_n_o),
  .cclk    (cfg_cclk_o),
  .data    (cfg_data_o),
  .s_valid (s_valid_i),
  .s_ready (s_ready_o),
  .busy    (busy_o),
  .ok      (ok_o),
  .err     (err_o),
  .code    (err_code_o)
);

// File: tb/fpga_cfg_loader_tb.sv
`timescale 1ns/1ps
module fpga_cfg_loader_tb;
  localparam int CNT_W   = 16;
  localparam int PROG    = 20;
  localparam int INIT_TO = 300;
  localparam int SETTLE  = 40;
  localparam int BUSY_TO = 60;
  localparam int DONE_TO = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic [CNT_W-1:0] total = '0;
  logic [7:0]       s_data = '0;
  logic             s_valid = 1'b0;
  logic             s_ready;
  logic             prog_n, cs_n, wr_n, cclk;
  logic [7:0]       cdata;
  logic             m_init_n = 1'b1, m_done = 1'b0, m_busy = 1'b0;
  logic             busy, ok, err;
  logic [2:0]       code;
  logic [CNT_W-1:0] offset;

  fpga_cfg_loader #(
    .CNT_W(CNT_W), .TMR_W(27), .SYNC_STAGES(2), .PROG_CYC(PROG),
    .INIT_TO_CYC(INIT_TO), .SETTLE_CYC(SETTLE), .BUSY_TO_CYC(BUSY_TO),
    .DONE_TO_CYC(DONE_TO), .CHECK_BUSY(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .total_bytes_i(total),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .cfg_prog_n_o(prog_n), .cfg_cs_n_o(cs_n), .cfg_wr_n_o(wr_n),
    .cfg_cclk_o(cclk), .cfg_data_o(cdata), .cfg_init_n_i(m_init_n),
    .cfg_done_i(m_done), .cfg_busy_i(m_busy), .busy_o(busy), .ok_o(ok),
    .err_o(err), .err_code_o(code), .err_offset_o(offset)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(bit cond, string req, string what, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  bit   no_lo = 0, no_hi = 0;
  int   err_at = 0, done_at = 0, stuck_at = 0;
  logic [7:0] rx [64];
  int   rx_cnt = 0, plo_cnt = 0, pw = 0, rel_cnt = 0, bcnt = 0;
  int   st_cnt = 0, settle = 0;
  bit   err_flag = 0, stuck = 0, st_meas = 0;
  logic prev_cclk = 1'b1, prev_cs = 1'b1, prev_prog = 1'b1;

  always @(posedge clk) begin
    prev_cclk <= cclk;
    prev_cs   <= cs_n;
    prev_prog <= prog_n;
    if (!prog_n) begin
      plo_cnt  <= plo_cnt + 1;
      rx_cnt   <= 0;
      m_done   <= 1'b0;
      m_busy   <= 1'b0;
      err_flag <= 1'b0;
      stuck    <= 1'b0;
      bcnt     <= 0;
      rel_cnt  <= 0;
      if (plo_cnt == 3 && !no_lo) m_init_n <= 1'b0;
    end else begin
      if (!prev_prog) begin pw <= plo_cnt; plo_cnt <= 0; end
      if (!m_init_n && !err_flag) begin
        rel_cnt <= rel_cnt + 1;
        if (rel_cnt == 5 && !no_hi) m_init_n <= 1'b1;
      end
      if (cclk && !prev_cclk && !cs_n && !wr_n) begin
        rx[rx_cnt] <= cdata;
        rx_cnt     <= rx_cnt + 1;
        m_busy     <= 1'b1;
        bcnt       <= 2;
        if (rx_cnt + 1 == err_at)   begin m_init_n <= 1'b0; err_flag <= 1'b1; end
        if (rx_cnt + 1 == done_at)  m_done <= 1'b1;
        if (rx_cnt + 1 == stuck_at) stuck <= 1'b1;
      end else if (bcnt != 0) begin
        bcnt <= bcnt - 1;
        if (bcnt == 1 && !stuck) m_busy <= 1'b0;
      end
    end
    if (!cs_n && prev_cs) begin st_meas <= 1'b1; st_cnt <= 0; end
    else if (st_meas) begin
      st_cnt <= st_cnt + 1;
      if (!cclk && prev_cclk) begin settle <= st_cnt; st_meas <= 1'b0; end
    end
  end

  // ---------------- stream source ----------------
  logic [7:0] src [64];
  int  idx = 0, n_src = 0;
  bit  pend = 0;

  always @(negedge clk) begin
    if (pend) idx = idx + 1;
    if (idx < n_src && ($urandom % 4 != 0)) begin
      s_valid = 1'b1;
      s_data  = src[idx];
    end else begin
      s_valid = 1'b0;
    end
    pend = s_valid && s_ready;
  end

  // ---------------- expectation ----------------
  function automatic void expect_of(int n, int e, int d, int b, bit lo, bit hi,
                                    output int x_code, output int x_bytes);
    x_code = 0; x_bytes = 0;
    if (lo) begin x_code = 1; return; end
    if (hi) begin x_code = 2; return; end
    for (int i = 1; i <= n; i++) begin
      if (i == e) begin x_code = 3; x_bytes = i; return; end
      if (i == b) begin x_code = 5; x_bytes = i; return; end
      if (i == d) begin x_code = 0; x_bytes = i; return; end
    end
    x_bytes = n;
    x_code  = (d == 0) ? 4 : 0;
  endfunction

  function automatic string req_of(int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R7";
      4: return "R10";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_case(int n, int e, int d, int b, bit lo, bit hi, bit mid);
    int x_code, x_bytes, mism;
    bit fin;
    expect_of(n, e, d, b, lo, hi, x_code, x_bytes);
    @(negedge clk); #1;
    no_lo = lo; no_hi = hi; err_at = e; done_at = d; stuck_at = b;
    for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
    idx = 0; pend = 0; n_src = n; s_valid = 1'b0;
    total = CNT_W'(n);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (mid) begin
      repeat (60) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      chk(busy == 1'b1, "R11", "busy_o after ignored start", int'(busy), 1);
    end
    fin = 0;
    for (int i = 0; i < 6000 && !fin; i++) begin
      @(negedge clk);
      if (!busy) fin = 1;
    end
    chk(fin, "R11", "sequence finished", int'(fin), 1);
    chk(int'(code) == x_code, req_of(x_code), "err_code", int'(code), x_code);
    chk(ok == (x_code == 0), req_of(x_code), "ok_o", int'(ok), int'(x_code == 0));
    chk(err == (x_code != 0), req_of(x_code), "err_o", int'(err), int'(x_code != 0));
    if (x_code != 0 && x_code != 1 && x_code != 2)
      chk(int'(offset) == x_bytes, req_of(x_code), "err_offset", int'(offset), x_bytes);
    if (x_code == 1)
      chk(int'(offset) == 0, "R3", "err_offset", int'(offset), 0);
    chk(rx_cnt == x_bytes, (d != 0 && d < n) ? "R8" : "R6", "bytes clocked", rx_cnt, x_bytes);
    mism = 0;
    for (int i = 0; i < x_bytes && i < 64; i++) if (rx[i] !== src[i]) mism++;
    chk(mism == 0, "R6", "byte mismatches", mism, 0);
    if (x_code == 0) begin
      chk(pw >= PROG, "R2", "program pulse cycles", pw, PROG);
      chk(settle >= SETTLE, "R5", "settle cycles", settle, SETTLE);
      chk(cs_n && wr_n, "R10", "cs_n&wr_n released", int'(cs_n && wr_n), 1);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(prog_n && cs_n && wr_n && cclk, "R1", "idle pins", int'({prog_n, cs_n, wr_n, cclk}), 15);
    chk(!busy && !ok && !err, "R1", "status flags", int'({busy, ok, err}), 0);
    chk(!s_ready, "R1", "s_ready_o", int'(s_ready), 0);

    // clean loads of random length
    for (int k = 0; k < 3; k++) begin
      int n = 8 + int'($urandom % 30);
      run_case(n, 0, n, 0, 0, 0, 0);
    end
    run_case(20, 0, 20, 0, 0, 0, 1);   // R11 start mid-load ignored
    run_case(10, 0, 10, 0, 1, 0, 0);   // R3 INIT never falls
    run_case(10, 0, 10, 0, 0, 1, 0);   // R4 INIT never rises
    run_case(12, 5, 12, 0, 0, 0, 0);   // R7 INIT fault at byte 5
    run_case(20, 0, 7, 0, 0, 0, 0);    // R8 DONE early at byte 7
    run_case(10, 0, 0, 0, 0, 0, 0);    // R10 DONE never rises
    run_case(10, 0, 10, 4, 0, 0, 0);   // R9 BUSY stuck after byte 4
    run_case(1, 0, 1, 0, 0, 0, 0);     // R6 single byte after abort
    run_case(0, 0, 0, 0, 0, 0, 0);     // R10 zero bytes, no DONE
    run_case(12, 1, 12, 0, 0, 0, 0);   // R7 fault on first byte

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule